// File: doc/BRIEF.md
# Framed Synchronous Serial Data Streamer

This block sends a contiguous run of 32-bit words from a word memory out over a three-wire synchronous link: a serial clock, a serial data line and a frame pulse. Each frame-start strobe (one per multiplexer frame) launches one transfer. The block reads every word from the start address up to and including the end address through a synchronous memory read port. It shifts each word out most significant bit first, with no gap between words.

The serial clock comes from dividing the system clock. One select input picks a slow rate or a fast rate that is twice as quick. The frame pulse can mark the whole block once, or every 8-bit, 16-bit or 32-bit field, and its level can be inverted. With clock gating on, the serial clock only toggles around a transfer, with a fixed margin of three periods before and after. A strobe that arrives while a transfer is running is dropped and raises a sticky overrun flag.

Top module: `frame_serial_streamer`

## Requirements
- R1: The words at the start address through the end address inclusive are sent most significant bit first. The address counts up modulo 2^ADDR_W, so an end address below the start address wraps through the top of the address space.
- R2: Serial data changes only on a rising edge of the serial clock and holds for one full serial period. It is 0 whenever no data bit is being sent.
- R3: The frame pulse lasts one serial period and changes only on a rising edge of the serial clock. It is asserted in the period just before the first data bit of each field.
- R4: The field-size code is 0 for one pulse per block, 1 for 8-bit fields, 2 for 16-bit fields and 3 for 32-bit fields. No pulse follows the last bit of the block.
- R5: When the invert input is 1, the frame output is inverted: its idle level is 1 and the pulse is 0.
- R6: With clock gating on, the serial clock toggles from three periods before the first frame pulse until three periods after the last data bit, and stays low otherwise. With gating off it toggles all the time.
- R7: Serial period 0 starts in the system cycle after the accepted strobe. The first frame pulse falls in period 3 at the slow rate (2*HALF_SLOW system cycles per period) and in period 4 at the fast rate (2*HALF_FAST cycles). Each period starts with the clock high for its first half.
- R8: The memory read of the start address is issued in the cycle after the strobe is accepted. Each word is read exactly once, and the next word is prefetched so that the bit stream has no gap between words.
- R9: A strobe during a transfer is ignored and sets the overrun flag. The next accepted strobe clears the flag.
- R10: With the enable input low, strobes are ignored and no memory read is issued. Dropping enable during a transfer ends it at once, with data 0 and the frame output at its idle level.
- R11: Addresses, field size, invert and rate are sampled when the strobe is accepted. Changing those inputs during a transfer has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Block enable |
| frame_strobe_i | input | 1 | Multiplexer frame start, one cycle |
| start_addr_i | input | ADDR_W | First word address |
| end_addr_i | input | ADDR_W | Last word address, inclusive |
| field_size_i | input | 2 | Frame pulse granularity code |
| fp_invert_i | input | 1 | Inverts the frame output |
| clk_gate_i | input | 1 | 1: clock runs only around a transfer |
| fast_rate_i | input | 1 | 1: fast serial rate |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_addr_o | output | ADDR_W | Memory read address |
| mem_rdata_i | input | 32 | Read data, valid one cycle after the strobe |
| sclk_o | output | 1 | Serial clock |
| sdata_o | output | 1 | Serial data |
| sframe_o | output | 1 | Frame pulse |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
The bench compares every system cycle of each transfer against a bit-exact model, field size by field size. A design whose pulse lands one period late would put the pulse on the first bit instead of before it. One that forgets the end-of-block case would emit an extra pulse after the last bit. Transfers that wrap the address, use a single word, or run at the fast rate expose an off-by-one in the word count or a lead of three periods where four are required. Inputs are scrambled right after acceptance, so a design that reads them live corrupts the stream. A mid-transfer strobe and an enable drop show whether a design restarts, aborts, or fails to set and clear the overrun flag.

// File: rtl/ssd_pkg.sv
package ssd_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned BITS_W    = $clog2(WORD_W);
    localparam int unsigned LEAD_SLOW = 3;   // period index of first frame pulse, slow rate
    localparam int unsigned LEAD_FAST = 4;   // same, fast rate
    localparam int unsigned CLK_LEAD  = 3;   // gated clock periods before first pulse
    localparam int unsigned CLK_TAIL  = 3;   // gated clock periods after last bit
    localparam int unsigned PER_W     = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TAIL
    } seq_state_e;

    typedef enum logic [1:0] {
        FLD_BLOCK = 2'd0,
        FLD_8     = 2'd1,
        FLD_16    = 2'd2,
        FLD_32    = 2'd3
    } field_e;

    typedef struct packed {
        field_e fsize;
        logic   inv;
        logic   gate;
        logic   fast;
    } xfer_cfg_t;

    // True when bit position pos is the final bit of a field of the given size.
    function automatic logic field_last_bit(field_e f, logic [BITS_W-1:0] pos);
        case (f)
            FLD_8:   return &pos[2:0];
            FLD_16:  return &pos[3:0];
            FLD_32:  return &pos;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/ssd_phase.sv
module ssd_phase #(
    parameter int unsigned HALF_SLOW = 20,
    parameter int unsigned HALF_FAST = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic fast,
    output logic tick,
    output logic sclk_hi
);
    localparam int unsigned PH_W      = $clog2(2 * HALF_SLOW);
    localparam logic [PH_W-1:0] LAST_S = PH_W'(2 * HALF_SLOW - 1);
    localparam logic [PH_W-1:0] LAST_F = PH_W'(2 * HALF_FAST - 1);
    localparam logic [PH_W-1:0] HALF_S = PH_W'(HALF_SLOW);
    localparam logic [PH_W-1:0] HALF_F = PH_W'(HALF_FAST);

    logic [PH_W-1:0] ph;
    logic [PH_W-1:0] last_ph;
    logic [PH_W-1:0] half_ph;

    always_comb begin
        last_ph = fast ? LAST_F : LAST_S;
        half_ph = fast ? HALF_F : HALF_S;
        tick    = (ph >= last_ph);
        sclk_hi = (ph < half_ph);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            ph <= '0;
        end else if (tick) begin
            ph <= '0;
        end else begin
            ph <= ph + 1'b1;
        end
    end
endmodule

// File: rtl/ssd_fetch.sv
module ssd_fetch
    import ssd_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              issue,
    input  logic [ADDR_W-1:0] issue_addr,
    input  logic              issue_last,
    output logic              mem_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic [WORD_W-1:0] buf_word,
    output logic              buf_last
);
    logic rd_q;
    logic pend_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_rd_o   <= 1'b0;
            mem_addr_o <= '0;
            rd_q       <= 1'b0;
            pend_last  <= 1'b0;
            buf_word   <= '0;
            buf_last   <= 1'b0;
        end else if (flush) begin
            mem_rd_o <= 1'b0;
            rd_q     <= 1'b0;
        end else begin
            mem_rd_o <= issue;
            rd_q     <= mem_rd_o;
            if (issue) begin
                mem_addr_o <= issue_addr;
                pend_last  <= issue_last;
            end
            if (rd_q) begin
                buf_word <= mem_rdata_i;
                buf_last <= pend_last;
            end
        end
    end
endmodule

// File: rtl/ssd_seq.sv
module ssd_seq
    import ssd_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable_i,
    input  logic              strobe_i,
    input  logic [ADDR_W-1:0] start_i,
    input  logic [ADDR_W-1:0] end_i,
    input  logic [1:0]        field_i,
    input  logic              inv_i,
    input  logic              gate_i,
    input  logic              fast_i,
    input  logic              tick,
    input  logic [WORD_W-1:0] buf_word,
    input  logic              buf_last,
    output logic              accept,
    output logic              cfg_fast,
    output logic              issue,
    output logic [ADDR_W-1:0] issue_addr,
    output logic              issue_last,
    output logic              flush,
    output logic              sdata,
    output logic              sframe,
    output logic              clk_win,
    output logic              overrun,
    output logic              busy
);
    seq_state_e        state;
    logic [PER_W-1:0]  per;
    logic [PER_W-1:0]  lead_idx;
    logic [BITS_W-1:0] bitcnt;
    logic [BITS_W-1:0] nb;
    logic [WORD_W-1:0] sreg;
    logic              sreg_last;
    logic [ADDR_W-1:0] next_addr;
    logic [ADDR_W-1:0] cfg_end;
    xfer_cfg_t         cfg;
    xfer_cfg_t         cfg_in;
    logic              fp_r;
    logic              load_lead;
    logic              word_end;
    logic              load_word;

    always_comb begin
        cfg_in    = '{fsize: field_e'(field_i), inv: inv_i, gate: gate_i, fast: fast_i};
        lead_idx  = cfg.fast ? PER_W'(LEAD_FAST) : PER_W'(LEAD_SLOW);
        accept    = enable_i && strobe_i && (state == ST_IDLE);
        load_lead = tick && (state == ST_LEAD) && (per == lead_idx);
        word_end  = tick && (state == ST_SHIFT) && (bitcnt == BITS_W'(WORD_W - 1));
        load_word = load_lead || (word_end && !sreg_last);
        issue     = enable_i && (accept || (load_word && !buf_last));
        issue_addr = accept ? start_i : next_addr;
        issue_last = accept ? (start_i == end_i) : (next_addr == cfg_end);
        flush     = !enable_i;
        nb        = bitcnt + 1'b1;
        busy      = (state != ST_IDLE);
        cfg_fast  = cfg.fast;
        sdata     = sreg[WORD_W-1];
        sframe    = fp_r ^ cfg.inv;
        clk_win   = !cfg.gate || (state == ST_SHIFT) || (state == ST_TAIL) ||
                    ((state == ST_LEAD) && (per >= lead_idx - PER_W'(CLK_LEAD)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            per       <= '0;
            bitcnt    <= '0;
            sreg      <= '0;
            sreg_last <= 1'b0;
            next_addr <= '0;
            cfg_end   <= '0;
            cfg       <= '{fsize: FLD_BLOCK, inv: 1'b0, gate: 1'b1, fast: 1'b0};
            fp_r      <= 1'b0;
            overrun   <= 1'b0;
        end else if (!enable_i) begin
            state <= ST_IDLE;
            fp_r  <= 1'b0;
            sreg  <= '0;
            cfg   <= cfg_in;
        end else begin
            if (state == ST_IDLE) begin
                cfg <= cfg_in;
            end
            if (accept) begin
                state     <= ST_LEAD;
                per       <= '0;
                fp_r      <= 1'b0;
                next_addr <= start_i + 1'b1;
                cfg_end   <= end_i;
                overrun   <= 1'b0;
            end else if (strobe_i && busy) begin
                overrun <= 1'b1;
            end

            if (load_word) begin
                state     <= ST_SHIFT;
                sreg      <= buf_word;
                sreg_last <= buf_last;
                bitcnt    <= '0;
                fp_r      <= 1'b0;
                if (!buf_last) begin
                    next_addr <= next_addr + 1'b1;
                end
            end else if (tick) begin
                case (state)
                    ST_LEAD: begin
                        per  <= per + 1'b1;
                        fp_r <= ((per + 1'b1) == lead_idx);
                    end
                    ST_SHIFT: begin
                        sreg <= sreg << 1;
                        if (word_end) begin
                            state <= ST_TAIL;
                            per   <= '0;
                            fp_r  <= 1'b0;
                        end else begin
                            bitcnt <= nb;
                            fp_r   <= field_last_bit(cfg.fsize, nb) &&
                                      !(sreg_last && (nb == BITS_W'(WORD_W - 1)));
                        end
                    end
                    ST_TAIL: begin
                        if (per == PER_W'(CLK_TAIL - 1)) begin
                            state <= ST_IDLE;
                        end else begin
                            per <= per + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/frame_serial_streamer.sv
module frame_serial_streamer
    import ssd_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned HALF_SLOW = 20,
    parameter int unsigned HALF_FAST = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable_i,
    input  logic              frame_strobe_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [ADDR_W-1:0] end_addr_i,
    input  logic [1:0]        field_size_i,
    input  logic              fp_invert_i,
    input  logic              clk_gate_i,
    input  logic              fast_rate_i,
    output logic              mem_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic              sclk_o,
    output logic              sdata_o,
    output logic              sframe_o,
    output logic              overrun_o
);
    logic              accept;
    logic              cfg_fast;
    logic              tick;
    logic              sclk_hi;
    logic              issue;
    logic [ADDR_W-1:0] issue_addr;
    logic              issue_last;
    logic              flush;
    logic [WORD_W-1:0] buf_word;
    logic              buf_last;
    logic              clk_win;
    logic              busy;

    ssd_phase #(
        .HALF_SLOW (HALF_SLOW),
        .HALF_FAST (HALF_FAST)
    ) u_phase (
        .clk     (clk),
        .rst     (rst),
        .restart (accept),
        .fast    (cfg_fast),
        .tick    (tick),
        .sclk_hi (sclk_hi)
    );

    ssd_fetch #(
        .ADDR_W (ADDR_W)
    ) u_fetch (
        .clk         (clk),
        .rst         (rst),
        .flush       (flush),
        .issue       (issue),
        .issue_addr  (issue_addr),
        .issue_last  (issue_last),
        .mem_rd_o    (mem_rd_o),
        .mem_addr_o  (mem_addr_o),
        .mem_rdata_i (mem_rdata_i),
        .buf_word    (buf_word),
        .buf_last    (buf_last)
    );

    ssd_seq #(
        .ADDR_W (ADDR_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .enable_i   (enable_i),
        .strobe_i   (frame_strobe_i),
        .start_i    (start_addr_i),
        .end_i      (end_addr_i),
        .field_i    (field_size_i),
        .inv_i      (fp_invert_i),
        .gate_i     (clk_gate_i),
        .fast_i     (fast_rate_i),
        .tick       (tick),
        .buf_word   (buf_word),
        .buf_last   (buf_last),
        .accept     (accept),
        .cfg_fast   (cfg_fast),
        .issue      (issue),
        .issue_addr (issue_addr),
        .issue_last (issue_last),
        .flush      (flush),
        .sdata      (sdata_o),
        .sframe     (sframe_o),
        .clk_win    (clk_win),
        .overrun    (overrun_o),
        .busy       (busy)
    );

    assign sclk_o = clk_win && sclk_hi;
endmodule

// File: rtl/ssd_checker.sv
module ssd_checker (
    input logic clk,
    input logic rst,
    input logic enable_i,
    input logic frame_strobe_i,
    input logic clk_gate_i,
    input logic sclk_o,
    input logic sdata_o,
    input logic sframe_o,
    input logic mem_rd_o,
    input logic overrun_o,
    input logic busy
);
    // R2: data moves only together with a rising serial clock
    assert_data_on_rise_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(enable_i) && enable_i && !$stable(sdata_o)) |-> (sclk_o && !$past(sclk_o)));

    // R2: no data while idle
    assert_idle_data_low_R2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sdata_o);

    // R3: frame pulse edges coincide with serial clock rises during a transfer
    assert_frame_on_rise_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && $past(enable_i) && !$stable(sframe_o)) |-> (sclk_o && !$past(sclk_o)));

    // R6: gated clock stays low while idle
    assert_gated_idle_low_R6: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(!busy) && $past(clk_gate_i)) |-> !sclk_o);

    // R8: first read follows an accepted strobe
    assert_first_read_R8: assert property (@(posedge clk) disable iff (rst)
        (!busy && enable_i && frame_strobe_i) |=> (mem_rd_o && busy && !overrun_o));

    // R9: strobe during a transfer raises overrun
    assert_overrun_set_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && enable_i && frame_strobe_i) |=> overrun_o);

    // R10: disabled block is idle and does not read
    assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !$past(enable_i) |-> (!busy && !mem_rd_o));
endmodule

bind frame_serial_streamer ssd_checker u_ssd_checker (
    .clk            (clk),
    .rst            (rst),
    .enable_i       (enable_i),
    .frame_strobe_i (frame_strobe_i),
    .clk_gate_i     (clk_gate_i),
    .sclk_o         (sclk_o),
    .sdata_o        (sdata_o),
    .sframe_o       (sframe_o),
    .mem_rd_o       (mem_rd_o),
    .overrun_o      (overrun_o),
    .busy           (busy)
);

// File: tb/test_frame_serial_streamer.sv
`timescale 1ns/1ps
module test_frame_serial_streamer;
    localparam int AW = 8;
    localparam int HS = 20;
    localparam int HF = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en = 1'b0;
    logic          strobe = 1'b0;
    logic [AW-1:0] s_addr = '0;
    logic [AW-1:0] e_addr = '0;
    logic [1:0]    fsize = 2'd0;
    logic          inv = 1'b0;
    logic          gate = 1'b1;
    logic          fast = 1'b0;
    logic          mem_rd;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_rdata = '0;
    logic          sclk;
    logic          sdata;
    logic          sframe;
    logic          overrun;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    frame_serial_streamer #(.ADDR_W(AW), .HALF_SLOW(HS), .HALF_FAST(HF)) i_frame_serial_streamer (
        .clk(clk), .rst(rst), .enable_i(en), .frame_strobe_i(strobe),
        .start_addr_i(s_addr), .end_addr_i(e_addr), .field_size_i(fsize),
        .fp_invert_i(inv), .clk_gate_i(gate), .fast_rate_i(fast),
        .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
        .sclk_o(sclk), .sdata_o(sdata), .sframe_o(sframe), .overrun_o(overrun)
    );

    function automatic logic [31:0] word_at(logic [AW-1:0] a);
        return {a, ~a, a ^ 8'h5A, a + 8'd3};
    endfunction

    always @(posedge clk) if (mem_rd) mem_rdata <= word_at(mem_addr);

    task automatic chk(input string req, input bit ok, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One full transfer, checked every system cycle against the model.
    task automatic run_xfer(input logic [AW-1:0] s, input logic [AW-1:0] e, input logic [1:0] fs,
                            input logic iv, input logic gt, input logic fa, input int ovr_at,
                            output logic ov_first);
        int L = fa ? 4 : 3;
        int P = fa ? 2*HF : 2*HS;
        int nw = int'(8'(e - s)) + 1;
        int n = nw * 32;
        int nper = L + n + 5;
        int derr = 0, ferr = 0, cerr = 0, reads = 0;
        int dact = 0, dexp = 0, fact = 0, fexp = 0, cact = 0, cexp = 0;
        @(negedge clk);
        s_addr = s; e_addr = e; fsize = fs; inv = iv; gate = gt; fast = fa; en = 1'b1; strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        for (int c = 0; c < nper * P; c++) begin
            int k = c / P;
            int ph = c % P;
            logic ec, ed, ef;
            if (c > 0) @(negedge clk);
            if (c == 0) begin
                ov_first = overrun;
                // R11: scramble sampled settings after acceptance
                s_addr = s ^ 8'h33; e_addr = e ^ 8'h0F; fsize = fs ^ 2'd1; inv = ~iv; fast = ~fa;
            end
            if (c == ovr_at) strobe = 1'b1;
            if (c == ovr_at + 1) strobe = 1'b0;
            if (c == (L + n + 4) * P - 1) begin
                s_addr = s; e_addr = e; fsize = fs; inv = iv; fast = fa;
            end
            ec = (!gt || (k >= L - 3 && k <= L + n + 3)) && (ph < P / 2);
            ed = 1'b0;
            ef = (k == L);
            if (k > L && k <= L + n) begin
                int b = k - L - 1;
                ed = word_at(8'(s + b / 32))[31 - b % 32];
                case (fs)
                    2'd1: ef = (b % 8 == 7);
                    2'd2: ef = (b % 16 == 15);
                    2'd3: ef = (b % 32 == 31);
                    default: ef = 1'b0;
                endcase
                if (b == n - 1) ef = 1'b0;
            end
            ef = ef ^ iv;
            reads += int'(mem_rd);
            if (sdata !== ed && derr++ == 0) begin dact = int'(sdata); dexp = int'(ed); end
            if (k <= L + n + 3 && sframe !== ef && ferr++ == 0) begin fact = int'(sframe); fexp = int'(ef); end
            if (sclk !== ec && cerr++ == 0) begin cact = int'(sclk); cexp = int'(ec); end
        end
        chk("R1/R2 serial data stream", derr == 0, dact, dexp);
        chk("R3/R4/R5 frame pulse", ferr == 0, fact, fexp);
        chk("R6/R7 serial clock", cerr == 0, cact, cexp);
        chk("R8 one read per word", reads == nw, reads, nw);
        chk("R11 stream unaffected by input changes", derr == 0 && ferr == 0, derr + ferr, 0);
        if (ovr_at >= 0) chk("R9 overrun flag set", overrun == 1'b1, int'(overrun), 1);
    endtask

    task automatic t_reset();
        rst = 1'b1; en = 1'b0; gate = 1'b1;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R2 reset data low", sdata == 1'b0, int'(sdata), 0);
        chk("R5 reset frame idle", sframe == 1'b0, int'(sframe), 0);
        chk("R6 reset clock low", sclk == 1'b0, int'(sclk), 0);
        chk("R9 reset overrun clear", overrun == 1'b0, int'(overrun), 0);
        chk("R10 reset no read", mem_rd == 1'b0, int'(mem_rd), 0);
    endtask

    task automatic t_disabled();
        int rd = 0, bad = 0;
        @(negedge clk);
        en = 1'b0; inv = 1'b1; gate = 1'b1; strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        for (int c = 0; c < 6 * 2 * HS; c++) begin
            @(negedge clk);
            rd += int'(mem_rd);
            if (sdata !== 1'b0 || sframe !== 1'b1 || sclk !== 1'b0) bad++;
        end
        chk("R10 strobe ignored when disabled: reads", rd == 0, rd, 0);
        chk("R10 outputs idle when disabled", bad == 0, bad, 0);
    endtask

    task automatic t_abort();
        int bad = 0;
        @(negedge clk);
        s_addr = 8'd40; e_addr = 8'd42; fsize = 2'd3; inv = 1'b1; gate = 1'b1; fast = 1'b0;
        en = 1'b1; strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        repeat (7 * 2 * HS) @(negedge clk);
        en = 1'b0;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            if (sdata !== 1'b0 || sframe !== 1'b1 || mem_rd !== 1'b0) bad++;
        end
        chk("R10 enable drop aborts transfer", bad == 0, bad, 0);
        en = 1'b1;
        @(negedge clk);
        s_addr = 8'd77; strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        chk("R8 read issued after restart", mem_rd == 1'b1 && mem_addr == 8'd77, int'(mem_addr), 77);
        repeat ((3 + 96 + 5) * 2 * HS) @(negedge clk);
    endtask

    initial begin
        logic ov;
        t_reset();
        run_xfer(8'd4, 8'd6, 2'd3, 1'b0, 1'b1, 1'b0, -1, ov);    // R1 R4 R7 slow, 32-bit fields
        run_xfer(8'd10, 8'd11, 2'd1, 1'b1, 1'b1, 1'b1, -1, ov);  // R4 R5 R7 fast, 8-bit fields, inverted
        run_xfer(8'd20, 8'd20, 2'd0, 1'b0, 1'b1, 1'b0, -1, ov);  // R4 single word, one pulse
        run_xfer(8'd30, 8'd31, 2'd2, 1'b0, 1'b0, 1'b0, 1000, ov); // R6 ungated, R9 overrun mid-stream
        run_xfer(8'd254, 8'd1, 2'd3, 1'b1, 1'b1, 1'b1, -1, ov);  // R1 address wrap
        chk("R9 overrun cleared by next accepted strobe", ov == 1'b0, int'(ov), 0);
        t_disabled();
        t_abort();
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule